// File: doc/BRIEF.md
# Auto Refresh Scheduler

This block sits beside the command arbiter of a DDR SDRAM controller and decides when an auto-refresh must go out. A free-running interval timer adds one owed refresh each time a programmable number of clock cycles has passed. For example, 1040 cycles at a 7.5 ns clock gives 7.8 µs, and 8192 such refreshes then fit in a 64 ms retention period. While any refresh is owed, the scheduler raises a request. It issues the refresh command only in a cycle where the arbiter both grants it and reports that every bank is precharged. It then holds off all other commands for the refresh cycle time.

Refreshes that the arbiter postpones build up in a debt counter, up to a configurable ceiling. When the ceiling is reached, an urgent flag tells the arbiter to stop postponing. The scheduler also drives the memory clock-enable for self refresh. Self refresh is entered when the controller asks for it and all banks are idle. On exit, clock-enable returns high and a hold-off window of tXSNR cycles keeps other commands back. While the device refreshes itself, owed refreshes are forgiven and the interval timer is held at zero.

The controller is a state machine with six states:
- `RS_IDLE`: nothing owed.
- `RS_PEND`: request raised.
- `RS_ISSUE`: one-cycle command.
- `RS_TRFC`: post-refresh hold-off.
- `RS_SELF`: clock-enable low.
- `RS_EXIT`: self-refresh exit hold-off.

Its transitions are:
- IDLE→PEND when debt is non-zero.
- IDLE/PEND→SELF when self refresh is requested and all banks are idle. This takes priority over a refresh.
- PEND→ISSUE when grant and all-banks-idle are high together.
- ISSUE→TRFC always.
- TRFC→IDLE when the hold-off timer expires.
- SELF→EXIT when exit is requested.
- EXIT→IDLE when the hold-off timer expires.

Top module: `refresh_sched`

## Requirements
- R1: During and directly after reset, ref_req_o=0, ref_cmd_o=0, busy_o=0, ref_urgent_o=0 and cke_o=1.
- R2: One refresh is owed every INTERVAL_CYC cycles. With no earlier activity, ref_req_o first reads 1 in cycle INTERVAL_CYC+1 after reset release, and reads 0 in cycle INTERVAL_CYC.
- R3: ref_req_o stays high until banks_idle_i and grant_i are both 1 at the same clock edge. ref_cmd_o then pulses high for exactly one cycle after that edge, and ref_req_o drops in that cycle.
- R4: busy_o is high for exactly RFC_CYC cycles, starting with the ref_cmd_o cycle. It then returns low.
- R5: grant_i has no effect while ref_req_o is low: no ref_cmd_o pulse follows.
- R6: Owed refreshes saturate at DEBT_MAX, and each command removes one. From a saturated debt with grant held, exactly DEBT_MAX commands are issued before the request drops, provided no interval expires in between.
- R7: ref_urgent_o is 1 exactly while the owed count equals DEBT_MAX. It falls in the cycle after the first command that lowers the count.
- R8: Self refresh is entered from RS_IDLE or RS_PEND only when sr_enter_i and banks_idle_i are both 1 at an edge. In the following cycle cke_o=0, busy_o=1, ref_req_o=0. sr_enter_i with banks_idle_i=0 leaves cke_o at 1.
- R9: While cke_o is low, no request or command is raised, and owed refreshes are cleared. After exit, no request appears until a new interval expires.
- R10: sr_exit_i during self refresh sets cke_o=1 in the next cycle. busy_o stays high for XSNR_CYC cycles, starting with that cycle. The interval timer restarts from zero at the exit edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| banks_idle_i | input | 1 | All banks are precharged |
| grant_i | input | 1 | Arbiter grants the refresh slot |
| sr_enter_i | input | 1 | Request to enter self refresh |
| sr_exit_i | input | 1 | Request to leave self refresh |
| ref_req_o | output | 1 | A refresh is owed and waiting |
| ref_urgent_o | output | 1 | Owed count has reached its ceiling |
| ref_cmd_o | output | 1 | One-cycle auto-refresh command |
| busy_o | output | 1 | Other commands must be held off |
| cke_o | output | 1 | Memory clock-enable |

## Verification
On every cycle, the assertions check the following:
- A command comes only after a granted request with banks idle, and lasts one cycle.
- The post-refresh window never exceeds RFC_CYC cycles.
- Debt never exceeds its ceiling or underflows.
- Clock-enable low always means busy with no request or command, and clock-enable always rises into a busy window.

Only the bench scenarios can show the rest:
- the exact cycle of the first request;
- the full length of both hold-off windows;
- that a saturated debt drains in exactly DEBT_MAX commands;
- that self refresh forgives owed refreshes and restarts the interval.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [2:0] {
        RS_IDLE  = 3'd0,
        RS_PEND  = 3'd1,
        RS_ISSUE = 3'd2,
        RS_TRFC  = 3'd3,
        RS_SELF  = 3'd4,
        RS_EXIT  = 3'd5
    } rs_state_e;

endpackage

// File: rtl/rs_interval_timer.sv
module rs_interval_timer #(
    parameter int INTERVAL_CYC = 1040
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hold_i,
    output logic tick_o
);
    localparam int CNT_W = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (hold_i || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign tick_o = !hold_i && (cnt_q == LAST);

    // R2: the counter never leaves its range
    a_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);

endmodule

// File: rtl/rs_debt_counter.sv
module rs_debt_counter #(
    parameter int DEBT_MAX = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic add_i,
    input  logic take_i,
    output logic pending_o,
    output logic full_o
);
    localparam int DW = $clog2(DEBT_MAX + 1);
    localparam logic [DW-1:0] CEIL = DW'(DEBT_MAX);

    logic [DW-1:0] debt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            debt_q <= '0;
        end else if (clear_i) begin
            debt_q <= '0;
        end else begin
            unique case ({add_i, take_i})
                2'b10:   if (debt_q != CEIL) debt_q <= debt_q + DW'(1);
                2'b01:   debt_q <= debt_q - DW'(1);
                default: debt_q <= debt_q;
            endcase
        end
    end

    assign pending_o = (debt_q != '0);
    assign full_o    = (debt_q == CEIL);

    // R6: debt saturates at the ceiling
    a_r6_debt_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
        debt_q <= CEIL);

    // R6: a command is only taken against an owed refresh
    a_r6_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_i && !clear_i) |-> debt_q != '0);

endmodule

// File: rtl/rs_holdoff.sv
module rs_holdoff #(
    parameter int MAX_CYC = 16
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         load_i,
    input  logic [$clog2(MAX_CYC+1)-1:0] load_val_i,
    output logic                         done_o
);
    localparam int W = $clog2(MAX_CYC + 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign done_o = (cnt_q == '0);

    // R4 / R10: the count only moves down unless reloaded
    a_r4_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && cnt_q != '0) |=> cnt_q < $past(cnt_q));

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import rs_pkg::*;
#(
    parameter int INTERVAL_CYC = 1040,
    parameter int RFC_CYC      = 10,
    parameter int XSNR_CYC     = 12,
    parameter int DEBT_MAX     = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic banks_idle_i,
    input  logic grant_i,
    input  logic sr_enter_i,
    input  logic sr_exit_i,
    output logic ref_req_o,
    output logic ref_urgent_o,
    output logic ref_cmd_o,
    output logic busy_o,
    output logic cke_o
);
    localparam int HOLD_MAX = (RFC_CYC > XSNR_CYC) ? RFC_CYC : XSNR_CYC;
    localparam int HOLD_W   = $clog2(HOLD_MAX + 1);
    localparam logic [HOLD_W-1:0] RFC_LOAD  = HOLD_W'(RFC_CYC - 1);
    localparam logic [HOLD_W-1:0] XSNR_LOAD = HOLD_W'(XSNR_CYC - 1);

    rs_state_e         state_q, state_d;
    logic              tick, pending, full, hold_done;
    logic              hold_load;
    logic [HOLD_W-1:0] hold_val;

    rs_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_interval (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .hold_i (state_q == RS_SELF),
        .tick_o (tick)
    );

    rs_debt_counter #(.DEBT_MAX(DEBT_MAX)) u_debt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clear_i   (state_q == RS_SELF),
        .add_i     (tick),
        .take_i    (state_q == RS_ISSUE),
        .pending_o (pending),
        .full_o    (full)
    );

    rs_holdoff #(.MAX_CYC(HOLD_MAX)) u_hold (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (hold_load),
        .load_val_i (hold_val),
        .done_o     (hold_done)
    );

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= RS_IDLE;
        else         state_q <= state_d;
    end

    // Next state and timer load
    always_comb begin
        state_d   = state_q;
        hold_load = 1'b0;
        hold_val  = '0;
        unique case (state_q)
            RS_IDLE: begin
                if (sr_enter_i && banks_idle_i) state_d = RS_SELF;
                else if (pending)               state_d = RS_PEND;
            end
            RS_PEND: begin
                if (sr_enter_i && banks_idle_i) begin
                    state_d = RS_SELF;
                end else if (grant_i && banks_idle_i) begin
                    state_d   = RS_ISSUE;
                    hold_load = 1'b1;
                    hold_val  = RFC_LOAD;
                end
            end
            RS_ISSUE: state_d = RS_TRFC;
            RS_TRFC: begin
                if (hold_done) state_d = RS_IDLE;
            end
            RS_SELF: begin
                if (sr_exit_i) begin
                    state_d   = RS_EXIT;
                    hold_load = 1'b1;
                    hold_val  = XSNR_LOAD;
                end
            end
            RS_EXIT: begin
                if (hold_done) state_d = RS_IDLE;
            end
            default: state_d = RS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ref_req_o    = (state_q == RS_PEND);
        ref_cmd_o    = (state_q == RS_ISSUE);
        busy_o       = (state_q == RS_ISSUE) || (state_q == RS_TRFC) ||
                       (state_q == RS_SELF)  || (state_q == RS_EXIT);
        cke_o        = (state_q != RS_SELF);
        ref_urgent_o = full;
    end

    // Checker counter for the post-refresh window
    logic [15:0] rfc_age_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                           rfc_age_q <= '0;
        else if (state_q == RS_ISSUE || state_q == RS_TRFC)    rfc_age_q <= rfc_age_q + 16'd1;
        else                                                   rfc_age_q <= '0;
    end

    // R3: a command only follows a granted request with all banks idle
    a_r3_cmd_after_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ref_cmd_o |-> $past(ref_req_o && grant_i && banks_idle_i));

    // R3: the command is a single-cycle pulse
    a_r3_cmd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ref_cmd_o |=> !ref_cmd_o);

    // R4: busy covers the cycle after the command
    a_r4_busy_after_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ref_cmd_o |=> busy_o);

    // R4: the post-refresh window never exceeds RFC_CYC cycles
    a_r4_window_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == RS_ISSUE || state_q == RS_TRFC) |-> rfc_age_q < 16'(RFC_CYC));

    // R8 / R9: clock-enable low means busy and quiet
    a_r9_cke_low_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cke_o |-> (busy_o && !ref_req_o && !ref_cmd_o));

    // R10: clock-enable always rises into a hold-off window
    a_r10_exit_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cke_o) |-> busy_o);

endmodule

// File: tb/test_refresh_sched.sv
module test_refresh_sched;

    localparam int INTERVAL = 100;
    localparam int RFC      = 5;
    localparam int XSNR     = 7;
    localparam int DMAX     = 8;

    // Row bits: {banks_idle, grant, exp_req, exp_cmd, exp_busy, exp_cke}
    localparam logic [5:0] VEC [0:8] = '{
        6'b01_1001,   // R3 grant without idle: keep waiting
        6'b10_1001,   // R3 idle without grant: keep waiting
        6'b11_0111,   // R3 command pulse
        6'b11_0011,   // R4 hold-off
        6'b11_0011,   // R4
        6'b11_0011,   // R4
        6'b11_0011,   // R4 last busy cycle
        6'b11_0001,   // R4 back to idle, R5 grant ignored
        6'b11_0001    // R5 grant ignored
    };

    logic clk = 1'b0;
    logic rst_n, banks_idle, grant, sr_enter, sr_exit;
    logic req, urgent, cmd, busy, cke;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    refresh_sched #(
        .INTERVAL_CYC(INTERVAL), .RFC_CYC(RFC), .XSNR_CYC(XSNR), .DEBT_MAX(DMAX)
    ) i_refresh_sched (
        .clk_i(clk), .rst_ni(rst_n), .banks_idle_i(banks_idle), .grant_i(grant),
        .sr_enter_i(sr_enter), .sr_exit_i(sr_exit), .ref_req_o(req),
        .ref_urgent_o(urgent), .ref_cmd_o(cmd), .busy_o(busy), .cke_o(cke)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        cyc++;
    endtask

    task automatic wait_to(input int target);
        while (cyc < target) step();
    endtask

    initial begin
        #(5ns * 20000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int n_cmd;
        rst_n = 1'b0; banks_idle = 1'b0; grant = 1'b0; sr_enter = 1'b0; sr_exit = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        chk("R1 req in reset", req, 0);
        rst_n = 1'b1;
        cyc = 0;
        chk("R1 req", req, 0);
        chk("R1 cmd", cmd, 0);
        chk("R1 busy", busy, 0);
        chk("R1 urgent", urgent, 0);
        chk("R1 cke", cke, 1);

        // R2: first request timing
        wait_to(INTERVAL);
        chk("R2 no request yet", req, 0);
        step();
        chk("R2 first request", req, 1);

        // R3 / R4 / R5 vector walk
        for (int i = 0; i < 9; i++) begin
            banks_idle = VEC[i][5];
            grant      = VEC[i][4];
            step();
            chk($sformatf("R3/R4/R5 row %0d req", i), req, VEC[i][3]);
            chk($sformatf("R3/R4/R5 row %0d cmd", i), cmd, VEC[i][2]);
            chk($sformatf("R3/R4/R5 row %0d busy", i), busy, VEC[i][1]);
            chk($sformatf("R3/R4/R5 row %0d cke", i), cke, VEC[i][0]);
        end
        banks_idle = 1'b0;
        grant      = 1'b0;

        // R7: urgent rises when the eighth refresh is owed
        wait_to(9 * INTERVAL - 1);
        chk("R7 urgent below ceiling", urgent, 0);
        step();
        chk("R7 urgent at ceiling", urgent, 1);

        // R6: saturation past the ceiling, then drain
        wait_to(10 * INTERVAL + 1);
        chk("R6 still saturated", urgent, 1);
        banks_idle = 1'b1;
        grant      = 1'b1;
        n_cmd      = 0;
        while (cyc < 10 * INTERVAL + 81) begin
            step();
            if (cmd) n_cmd++;
            if (cyc == 10 * INTERVAL + 3) chk("R7 urgent falls after command", urgent, 0);
        end
        chk("R6 commands from saturated debt", n_cmd, DMAX);
        chk("R6 request drained", req, 0);
        grant = 1'b0;

        // R8: entry blocked while banks busy
        banks_idle = 1'b0;
        sr_enter   = 1'b1;
        wait_to(11 * INTERVAL + 1);
        chk("R8 cke stays high without idle banks", cke, 1);
        chk("R8 request still raised", req, 1);
        banks_idle = 1'b1;
        step();
        chk("R8 cke low", cke, 0);
        chk("R8 busy in self refresh", busy, 1);
        chk("R8 request dropped", req, 0);
        sr_enter = 1'b0;
        grant    = 1'b1;

        // R9: quiet through several intervals
        n_cmd = 0;
        while (cyc < 13 * INTERVAL) begin
            step();
            if (cmd || req) n_cmd++;
        end
        chk("R9 no request or command in self refresh", n_cmd, 0);
        chk("R9 cke still low", cke, 0);

        // R10: exit and hold-off
        sr_exit = 1'b1;
        step();
        chk("R10 cke high after exit", cke, 1);
        chk("R10 busy on exit", busy, 1);
        sr_exit = 1'b0;
        grant   = 1'b0;
        wait_to(13 * INTERVAL + XSNR);
        chk("R10 busy last exit cycle", busy, 1);
        step();
        chk("R10 busy released", busy, 0);
        wait_to(13 * INTERVAL + 10);
        chk("R9 owed refresh forgiven", req, 0);
        wait_to(14 * INTERVAL + 1);
        chk("R10 interval restarted, none yet", req, 0);
        step();
        chk("R10 request after fresh interval", req, 1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule